// File: doc/BRIEF.md
# Burst SRAM Cycle Sequencer

This block is the cycle-control front end of a single-cycle-deselect synchronous burst SRAM. At each rising clock edge it samples three chip selects, a sleep request, two burst-start strobes (one from a processor side, one from a controller side), a burst-advance input and a write qualifier decoded from global, group and per-lane write enables. From these it decides the cycle type (deselect, sleep, begin burst, continue burst or suspend burst), whether the cycle reads or writes, and which address feeds the array: the external address, the next address in the burst, or the current address.

A 2-bit linear burst counter provides the low address bits inside a burst. A small behavioural byte-lane memory sits behind the sequencer so that the read and write paths can be observed. The model is flow-through: read data for a cycle appears on the data output directly after the edge that registers its address. Write data is captured on the edge itself. The data-drive enable follows the output-enable pin without a clock, and it is forced low in write, deselect and sleep cycles.

Top module: `sbsram_seq`

## Requirements
- R1: While `sleep_req` is 1 at an edge, the cycle is sleep (`cycle_kind`=1, `addr_src`=0), `dout_oe` is 0, no write occurs and the burst address is held, so a later suspend still uses it.
- R2: With `sleep_req` 0, the cycle is deselect (`cycle_kind`=0, `addr_src`=0, `dout_oe`=0) if `sel_a_n`=1 and `start_ctrl_n`=0, or if `sel_a_n`=0, either strobe is 0, and `sel_b`=0 or `sel_c_n`=1.
- R3: When selected (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) with `start_host_n`=0, a burst begins (`cycle_kind`=2, `addr_src`=1) at `addr`, and the cycle is always a read: no write occurs, even with the write qualifier active.
- R4: When selected with `start_host_n`=1 and `start_ctrl_n`=0, a burst begins at `addr`. The cycle is a write (`cycle_wr`=1) when the write qualifier is active and a read otherwise.
- R5: With both strobes 1 (or `start_ctrl_n`=1 and `sel_a_n`=1, in which case `start_host_n` is ignored), `step_n`=0 continues the burst (`cycle_kind`=3, `addr_src`=2). The low 2 address bits step linearly with wrap from 3 to 0, and the upper bits are held.
- R6: Under the same strobe conditions, `step_n`=1 suspends the burst (`cycle_kind`=4, `addr_src`=3) and reuses the current address.
- R7: The write qualifier is active when `global_wr_n`=0, or when `group_wr_n`=0 and some `lane_wr_n` bit is 0. A write stores byte lane i (bits 8i+7..8i) only if `global_wr_n`=0, or `group_wr_n`=0 with `lane_wr_n[i]`=0.
- R8: `dout_oe` is 1 exactly when the current cycle is a read burst cycle and `out_en_n`=0. It follows `out_en_n` within the same clock period, without waiting for an edge, and it is 0 in write cycles.
- R9: In a read cycle, `dout` shows the word stored at the address registered at the edge that started the cycle.
- R10: After reset the cycle is deselect with `dout_oe` 0 and no burst active. A continue or suspend request while no burst is active, including after a deselect, is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request, active high |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| start_host_n | input | 1 | Processor-side burst start, read only, active low |
| start_ctrl_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Burst advance, active low |
| global_wr_n | input | 1 | Write all lanes, active low |
| group_wr_n | input | 1 | Enable per-lane writes, active low |
| lane_wr_n | input | BYTES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | External word address |
| din | input | 8*BYTES | Write data |
| dout | output | 8*BYTES | Read data |
| dout_oe | output | 1 | Data drive enable |
| cycle_kind | output | 3 | Current cycle: 0 deselect, 1 sleep, 2 begin, 3 continue, 4 suspend |
| cycle_wr | output | 1 | Current cycle is a write |
| addr_src | output | 2 | Address source: 0 none, 1 external, 2 next, 3 current |

## Verification
The cycle type, write flag and address source are registered, so each is due one edge after its inputs are applied. Read data and `dout_oe` follow combinationally from that edge. The bench sets inputs on the falling edge and queues the expected result. The monitor checks it 2 ns after the next rising edge, so every item is due exactly one edge after its stimulus. The asynchronous behaviour of `dout_oe` is checked separately: `out_en_n` is toggled in the middle of a cycle and the output is checked 1 ns later, with no edge in between.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_DESEL = 3'd0,
        CYC_SLEEP = 3'd1,
        CYC_BEGIN = 3'd2,
        CYC_CONT  = 3'd3,
        CYC_SUSP  = 3'd4
    } cyc_kind_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_NEXT = 2'd2,
        SRC_CUR  = 2'd3
    } addr_src_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      wr;
        addr_src_e src;
    } cyc_t;

    localparam cyc_t CYC_IDLE = '{kind: CYC_DESEL, wr: 1'b0, src: SRC_NONE};

    function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] c);
        return c + 1'b1;
    endfunction

    function automatic logic is_burst(input cyc_kind_e k);
        return (k == CYC_BEGIN) || (k == CYC_CONT) || (k == CYC_SUSP);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
`timescale 1ns/1ps
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             sleep_req,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             start_host_n,
    input  logic             start_ctrl_n,
    input  logic             step_n,
    input  logic             global_wr_n,
    input  logic             group_wr_n,
    input  logic [BYTES-1:0] lane_wr_n,
    input  logic             burst_live,
    output cyc_t             cyc,
    output logic [BYTES-1:0] lane_en
);

    logic wr_active;
    logic selected;
    logic any_strobe;

    assign wr_active  = ~global_wr_n | (~group_wr_n & ~(&lane_wr_n));
    assign selected   = ~sel_a_n & sel_b & ~sel_c_n;
    assign any_strobe = ~start_host_n | ~start_ctrl_n;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lane_en[b] = ~global_wr_n | (~group_wr_n & ~lane_wr_n[b]);
    end

    always_comb begin
        cyc = CYC_IDLE;
        if (sleep_req) begin
            cyc.kind = CYC_SLEEP;
        end else if (sel_a_n && !start_ctrl_n) begin
            cyc = CYC_IDLE;
        end else if (!sel_a_n && any_strobe && !selected) begin
            cyc = CYC_IDLE;
        end else if (!sel_a_n && !start_host_n) begin
            cyc.kind = CYC_BEGIN;
            cyc.src  = SRC_EXT;
            cyc.wr   = 1'b0;
        end else if (!start_ctrl_n) begin
            cyc.kind = CYC_BEGIN;
            cyc.src  = SRC_EXT;
            cyc.wr   = wr_active;
        end else if (!burst_live) begin
            cyc = CYC_IDLE;
        end else if (!step_n) begin
            cyc.kind = CYC_CONT;
            cyc.src  = SRC_NEXT;
            cyc.wr   = wr_active;
        end else begin
            cyc.kind = CYC_SUSP;
            cyc.src  = SRC_CUR;
            cyc.wr   = wr_active;
        end
    end

endmodule

// File: rtl/sbsram_addr.sv
`timescale 1ns/1ps
module sbsram_addr
    import sbsram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_t          cyc,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] tgt_addr,
    output logic [AW-1:0] cur_addr,
    output logic          burst_live
);

    localparam int HI_W = AW - BURST_W;

    always_comb begin
        unique case (cyc.src)
            SRC_EXT:  tgt_addr = ext_addr;
            SRC_NEXT: tgt_addr = {cur_addr[AW-1 -: HI_W], burst_step(cur_addr[BURST_W-1:0])};
            default:  tgt_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            burst_live <= 1'b0;
        end else begin
            unique case (cyc.kind)
                CYC_BEGIN: begin
                    cur_addr   <= tgt_addr;
                    burst_live <= 1'b1;
                end
                CYC_CONT, CYC_SUSP: cur_addr <= tgt_addr;
                CYC_DESEL: burst_live <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_CONT) |=>
            (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)) &&
            (cur_addr[AW-1 -: HI_W] == $past(cur_addr[AW-1 -: HI_W]))); // R5

    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_SUSP) |=> $stable(cur_addr)); // R6

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc.kind == CYC_SLEEP) |=> ($stable(cur_addr) && $stable(burst_live))); // R1

endmodule

// File: rtl/sbsram_store.sv
`timescale 1ns/1ps
module sbsram_store #(
    parameter int AW    = 4,
    parameter int BYTES = 2
) (
    input  logic               clk,
    input  logic               we,
    input  logic [BYTES-1:0]   lane_en,
    input  logic [AW-1:0]      waddr,
    input  logic [8*BYTES-1:0] wdata,
    input  logic [AW-1:0]      raddr,
    output logic [8*BYTES-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [8*BYTES-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < BYTES; b++) begin
            if (we && lane_en[b]) begin
                mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sbsram_seq.sv
`timescale 1ns/1ps
module sbsram_seq
    import sbsram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int BYTES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               sel_a_n,
    input  logic               sel_b,
    input  logic               sel_c_n,
    input  logic               start_host_n,
    input  logic               start_ctrl_n,
    input  logic               step_n,
    input  logic               global_wr_n,
    input  logic               group_wr_n,
    input  logic [BYTES-1:0]   lane_wr_n,
    input  logic               out_en_n,
    input  logic [AW-1:0]      addr,
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout,
    output logic               dout_oe,
    output logic [2:0]         cycle_kind,
    output logic               cycle_wr,
    output logic [1:0]         addr_src
);

    cyc_t             cyc_dec;
    cyc_t             cyc_q;
    logic [BYTES-1:0] lane_en;
    logic [AW-1:0]    tgt_addr;
    logic [AW-1:0]    cur_addr;
    logic             burst_live;
    logic             wr_now;
    logic             rd_cycle;

    sbsram_decode #(.BYTES(BYTES)) u_dec (
        .sleep_req    (sleep_req),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .start_host_n (start_host_n),
        .start_ctrl_n (start_ctrl_n),
        .step_n       (step_n),
        .global_wr_n  (global_wr_n),
        .group_wr_n   (group_wr_n),
        .lane_wr_n    (lane_wr_n),
        .burst_live   (burst_live),
        .cyc          (cyc_dec),
        .lane_en      (lane_en)
    );

    sbsram_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .cyc        (cyc_dec),
        .ext_addr   (addr),
        .tgt_addr   (tgt_addr),
        .cur_addr   (cur_addr),
        .burst_live (burst_live)
    );

    assign wr_now = ~rst & is_burst(cyc_dec.kind) & cyc_dec.wr;

    sbsram_store #(.AW(AW), .BYTES(BYTES)) u_mem (
        .clk     (clk),
        .we      (wr_now),
        .lane_en (lane_en),
        .waddr   (tgt_addr),
        .wdata   (din),
        .raddr   (cur_addr),
        .rdata   (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= CYC_IDLE;
        else     cyc_q <= cyc_dec;
    end

    assign rd_cycle   = is_burst(cyc_q.kind) & ~cyc_q.wr;
    assign dout_oe    = rd_cycle & ~out_en_n;
    assign cycle_kind = cyc_q.kind;
    assign cycle_wr   = cyc_q.wr;
    assign addr_src   = cyc_q.src;

    AST_HOST_READ: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && !sel_a_n && sel_b && !sel_c_n && !start_host_n) |=>
            (cycle_kind == CYC_BEGIN && !cycle_wr && addr_src == SRC_EXT)); // R3

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (cycle_kind == CYC_DESEL || cycle_kind == CYC_SLEEP) |-> !dout_oe); // R2

    AST_WR_MASKS_OE: assert property (@(posedge clk) disable iff (rst)
        cycle_wr |-> !dout_oe); // R8

    AST_ORPHAN_DESEL: assert property (@(posedge clk) disable iff (rst)
        (!burst_live && !sleep_req && start_ctrl_n && (start_host_n || sel_a_n)) |=>
            (cycle_kind == CYC_DESEL)); // R10

endmodule

// File: tb/sim_sbsram_seq.sv
`timescale 1ns/1ps
module sim_sbsram_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        sleep_req, sel_a_n, sel_b, sel_c_n;
    logic        start_host_n, start_ctrl_n, step_n;
    logic        global_wr_n, group_wr_n;
    logic [1:0]  lane_wr_n;
    logic        out_en_n;
    logic [3:0]  addr;
    logic [15:0] din;
    logic [15:0] dout;
    logic        dout_oe;
    logic [2:0]  cycle_kind;
    logic        cycle_wr;
    logic [1:0]  addr_src;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [15:0] VA = 16'hA1A1, VB = 16'hB2B2, VC = 16'hC3C3;
    localparam logic [15:0] VD = 16'hD4D4, VE = 16'hE5E5, VF = 16'h0F0F;

    always #5 clk = ~clk;

    sbsram_seq u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .start_host_n(start_host_n),
        .start_ctrl_n(start_ctrl_n), .step_n(step_n), .global_wr_n(global_wr_n),
        .group_wr_n(group_wr_n), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .cycle_kind(cycle_kind), .cycle_wr(cycle_wr), .addr_src(addr_src)
    );

    typedef struct {
        int          kind;
        bit          wr;
        int          src;
        bit          oe;
        bit          chk;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor: each queued item is due one edge after its stimulus
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(int'(cycle_kind) == e.kind, {e.tag, " kind"}, cycle_kind, e.kind);
            check(cycle_wr == e.wr, {e.tag, " wr"}, cycle_wr, e.wr);
            check(int'(addr_src) == e.src, {e.tag, " src"}, addr_src, e.src);
            check(dout_oe == e.oe, {e.tag, " oe"}, dout_oe, e.oe);
            if (e.chk) check(dout === e.data, {e.tag, " data"}, dout, e.data);
        end
    end

    // driver: push the expectation, then move to the next falling edge
    task automatic go(input string tag, input int kind, input bit wr, input int src,
                      input bit oe, input bit chk, input logic [15:0] data);
        exp_t e;
        e.kind = kind; e.wr = wr; e.src = src; e.oe = oe;
        e.chk = chk; e.data = data; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        sleep_req = 0; sel_a_n = 1; sel_b = 1; sel_c_n = 0;
        start_host_n = 1; start_ctrl_n = 1; step_n = 1;
        global_wr_n = 1; group_wr_n = 1; lane_wr_n = 2'b11;
        out_en_n = 0; addr = '0; din = '0;
    endtask

    task automatic pick();
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    endtask

    initial begin
        #50000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        check(cycle_kind == 3'd0, "R10 reset kind", cycle_kind, 0);
        check(dout_oe == 1'b0, "R10 reset oe", dout_oe, 0);

        // R4: controller-strobe begin, write at 6
        idle(); pick(); start_ctrl_n = 0; global_wr_n = 0; addr = 4'h6; din = VA;
        go("R4 begin write", 2, 1, 1, 0, 0, '0);
        // R5: continue write to 7, host strobe ignored while sel_a_n high
        idle(); start_host_n = 0; step_n = 0; global_wr_n = 0; din = VB;
        go("R5 continue write", 3, 1, 2, 0, 0, '0);
        // R5: wrap 7 -> 4
        idle(); step_n = 0; global_wr_n = 0; din = VC;
        go("R5 continue wrap", 3, 1, 2, 0, 0, '0);
        // R7: suspend write, lane 0 only
        idle(); group_wr_n = 0; lane_wr_n = 2'b10; din = VD;
        go("R7 suspend lane write", 4, 1, 3, 0, 0, '0);
        // R4 R9: controller-strobe begin read at 6
        idle(); pick(); start_ctrl_n = 0; addr = 4'h6;
        go("R9 begin read", 2, 0, 1, 1, 1, VA);
        idle(); step_n = 0;
        go("R9 continue read", 3, 0, 2, 1, 1, VB);
        idle(); step_n = 0;
        go("R5 R7 wrapped read", 3, 0, 2, 1, 1, {VC[15:8], VD[7:0]});
        // R6: suspend read, same address
        idle();
        go("R6 suspend read", 4, 0, 3, 1, 1, {VC[15:8], VD[7:0]});
        // R7: group enable with no lane active is a read
        idle(); pick(); start_ctrl_n = 0; group_wr_n = 0; lane_wr_n = 2'b11; addr = 4'h7;
        go("R7 no lane read", 2, 0, 1, 1, 1, VB);
        // R3: host strobe always reads
        idle(); pick(); start_host_n = 0; global_wr_n = 0; addr = 4'h6; din = VE;
        go("R3 host read", 2, 0, 1, 1, 1, VA);
        // R1: sleep
        idle(); sleep_req = 1; pick(); start_ctrl_n = 0; global_wr_n = 0; addr = 4'h2; din = VE;
        go("R1 sleep", 1, 0, 0, 0, 0, '0);
        idle();
        go("R1 resume suspend", 4, 0, 3, 1, 1, VA);
        // R2: deselects
        idle(); start_ctrl_n = 0;
        go("R2 deselect a", 0, 0, 0, 0, 0, '0);
        idle(); step_n = 0;
        go("R10 orphan continue", 0, 0, 0, 0, 0, '0);
        idle(); pick(); sel_b = 0; start_host_n = 0;
        go("R2 deselect b", 0, 0, 0, 0, 0, '0);
        idle(); pick(); sel_c_n = 1; start_ctrl_n = 0;
        go("R2 deselect c", 0, 0, 0, 0, 0, '0);
        // R8: read with output disabled, then toggle asynchronously
        idle(); pick(); start_ctrl_n = 0; addr = 4'h6; out_en_n = 1;
        go("R8 read oe off", 2, 0, 1, 0, 0, '0);
        idle(); out_en_n = 0;
        #1;
        check(dout_oe == 1'b1, "R8 async on", dout_oe, 1);
        check(dout === VA, "R8 async data", dout, VA);
        out_en_n = 1;
        #1;
        check(dout_oe == 1'b0, "R8 async off", dout_oe, 0);
        // R8: write masks output enable
        idle(); pick(); start_ctrl_n = 0; global_wr_n = 0; addr = 4'h9; din = VF;
        go("R8 write no drive", 2, 1, 1, 0, 0, '0);
        idle(); pick(); start_ctrl_n = 0; addr = 4'h9;
        go("R7 full word read", 2, 0, 1, 1, 1, VF);
        idle(); pick(); sel_b = 0; start_ctrl_n = 0;
        go("R2 final deselect", 0, 0, 0, 0, 0, '0);
        @(negedge clk);
        summary();
    end

endmodule